// File: doc/BRIEF.md
# Histogram Guardband Interrupt Controller

This block watches a stream of histogram segment values, one frame at a time, and compares each segment with its value from the previous frame. A frame counts as exceeding the guardband when any tracked segment has moved by more than a programmed threshold. When the number of consecutive exceeding frames reaches a programmed delay, the block records an event in a sticky status bit and, if enabled, raises a level interrupt. The histogram itself is built elsewhere. This block only sees the per-segment values as they stream past.

Software uses a single 32-bit control word. It holds an interrupt enable, the sticky status (cleared by writing 1 to it), an 8-bit frame delay and a 22-bit threshold. The delay and threshold are written to shadow copies. The copies that the comparison logic uses are loaded from the shadows on the vertical-blanking start pulse, so a mid-frame write never splits a frame's evaluation. A delay of zero is not meaningful. The block runs it as a delay of one and reports the condition on an error output.

Top module: `hgb_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000, `irq` is 0, and `delay_err` is 1 because the active delay is 0.
- R2: A write stores bit 31 as the enable, bits 29:22 as the shadow delay and bits 21:0 as the shadow threshold. The read value is {enable, status, shadow delay, shadow threshold} at bits 31, 30, 29:22 and 21:0, and a write shows up in it on the next cycle.
- R3: The active delay and active threshold copy the shadow values only in a cycle where `vblank_start` is 1. Until then the previous active values govern the comparison and `delay_err`.
- R4: A frame is exceeding when, for any of the first SEG_COUNT segments received since the previous `frame_end`, the absolute difference between the new value and that segment's value in the previous frame is strictly greater than the active threshold. An equal difference does not count, and segments beyond SEG_COUNT are ignored. Stored previous values start at 0 after reset.
- R5: On `frame_end`, an exceeding frame increments the consecutive-frame count, saturating at the effective delay. A non-exceeding frame resets the count to 0.
- R6: The status bit (bit 30) sets on a `frame_end` where the frame is exceeding and the count after the update equals the effective delay. It never sets at any other time.
- R7: Writing 1 to bit 30 clears the status bit. Writing 0 to bit 30 leaves it unchanged.
- R8: While the status bit is set, further events are not recorded. The bit stays set, whatever the frames do, until software clears it.
- R9: An active delay of 0 behaves as a delay of 1: a single exceeding frame is enough. `delay_err` is 1 exactly while the active delay is 0.
- R10: `irq` changes only on a cycle where `frame_end` is 1. At that cycle it takes the enable AND the status value that results from that frame.
- R11: With the enable at 0, `irq` is 0 after every `frame_end`, even though the status bit still records events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| frame_end | input | 1 | One-cycle strobe closing a frame's segment stream |
| seg_valid | input | 1 | Qualifies `seg_value`, one segment per cycle in index order |
| seg_value | input | 22 | Histogram value of the current segment |
| irq | output | 1 | Level interrupt |
| delay_err | output | 1 | Active delay is the invalid value 0 |

## Verification
The assertions assume that `seg_valid` and `frame_end` are never high in the same cycle. They also assume that a frame's segments arrive between two `frame_end` strobes, and that the interrupt relation is only judged on a `frame_end` cycle without a simultaneous register write. The bench drives every segment, strobe and write in a separate cycle on the falling edge, with `vblank_start` placed only between frames. As a result, each frame's evaluation sees one settled threshold, and each `frame_end` sees an enable that is not changing.

// File: rtl/hgb_pkg.sv
package hgb_pkg;
  localparam int REG_W   = 32;
  localparam int THR_W   = 22;
  localparam int DLY_W   = 8;
  localparam int EN_BIT  = 31;
  localparam int ST_BIT  = 30;

  typedef logic [THR_W-1:0] thr_t;
  typedef logic [DLY_W-1:0] dly_t;

  typedef struct packed {
    logic en;
    logic status;
    dly_t dly;
    thr_t thr;
  } ctl_word_t;

  // magnitude of change between two samples
  function automatic thr_t abs_diff(input thr_t a, input thr_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // strict comparison: equal distance is inside the guardband
  function automatic logic beyond_guard(input thr_t now_v, input thr_t old_v, input thr_t lim);
    return abs_diff(now_v, old_v) > lim;
  endfunction

  // zero is not a usable delay; run it as one frame
  function automatic dly_t eff_delay(input dly_t d);
    return (d == '0) ? dly_t'(1) : d;
  endfunction

  // count up, clamp at the limit (also clamps if already above it)
  function automatic dly_t sat_inc(input dly_t c, input dly_t lim);
    return (c >= lim) ? lim : dly_t'(c + dly_t'(1));
  endfunction
endpackage

// File: rtl/hgb_regfile.sv
module hgb_regfile
  import hgb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             vblank,
  input  logic             event_set,
  output logic [REG_W-1:0] rdata,
  output logic             en_q,
  output logic             status_q,
  output dly_t             act_dly,
  output thr_t             act_thr
);
  ctl_word_t w;
  dly_t      sh_dly;
  thr_t      sh_thr;
  logic      clr_req;

  assign w       = ctl_word_t'(wdata);
  assign clr_req = wr && w.status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      status_q <= 1'b0;
      sh_dly   <= '0;
      sh_thr   <= '0;
      act_dly  <= '0;
      act_thr  <= '0;
    end else begin
      if (wr) begin
        en_q   <= w.en;
        sh_dly <= w.dly;
        sh_thr <= w.thr;
      end
      // hardware set has priority over a same-cycle clear
      if (event_set)    status_q <= 1'b1;
      else if (clr_req) status_q <= 1'b0;
      if (vblank) begin
        act_dly <= sh_dly;
        act_thr <= sh_thr;
      end
    end
  end

  assign rdata = {en_q, status_q, sh_dly, sh_thr};
endmodule

// File: rtl/hgb_seg_tracker.sv
module hgb_seg_tracker
  import hgb_pkg::*;
#(
  parameter int SEG_COUNT = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic seg_valid,
  input  thr_t seg_value,
  input  logic frame_end,
  input  thr_t act_thr,
  output logic frame_hit
);
  localparam int IDX_W = $clog2(SEG_COUNT + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(SEG_COUNT);

  logic [IDX_W-1:0]     idx_q;
  logic [SEG_COUNT-1:0] seg_hit;
  logic                 hit_q;
  logic                 any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                             idx_q <= '0;
    else if (frame_end)                     idx_q <= '0;
    else if (seg_valid && idx_q != IDX_END) idx_q <= idx_q + IDX_W'(1);
  end

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    thr_t prev_q;
    logic take;
    assign take = seg_valid && (idx_q == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)    prev_q <= '0;
      else if (take) prev_q <= seg_value;
    end
    assign seg_hit[g] = take && beyond_guard(seg_value, prev_q, act_thr);
  end

  assign any_hit = |seg_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)         hit_q <= 1'b0;
    else if (frame_end) hit_q <= 1'b0;
    else if (any_hit)   hit_q <= 1'b1;
  end

  assign frame_hit = hit_q;
endmodule

// File: rtl/hgb_frame_counter.sv
module hgb_frame_counter
  import hgb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic frame_hit,
  input  dly_t act_dly,
  input  logic status_q,
  output dly_t frame_cnt,
  output dly_t eff_dly,
  output logic event_set,
  output logic delay_err
);
  dly_t cnt_q;
  dly_t cnt_up;
  logic reach;

  assign eff_dly   = eff_delay(act_dly);
  assign cnt_up    = sat_inc(cnt_q, eff_dly);
  assign reach     = frame_hit && (cnt_up == eff_dly);
  assign event_set = frame_end && reach && !status_q;
  assign delay_err = (act_dly == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (frame_end) cnt_q <= frame_hit ? cnt_up : '0;
  end

  assign frame_cnt = cnt_q;
endmodule

// File: rtl/hgb_irq_ctrl.sv
module hgb_irq_ctrl
  import hgb_pkg::*;
#(
  parameter int SEG_COUNT = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             vblank_start,
  input  logic             frame_end,
  input  logic             seg_valid,
  input  logic [THR_W-1:0] seg_value,
  output logic             irq,
  output logic             delay_err
);
  logic en_q, status_q, frame_hit, event_set, irq_q;
  dly_t act_dly, frame_cnt, eff_dly;
  thr_t act_thr;

  hgb_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .vblank   (vblank_start),
    .event_set(event_set),
    .rdata    (reg_rdata),
    .en_q     (en_q),
    .status_q (status_q),
    .act_dly  (act_dly),
    .act_thr  (act_thr)
  );

  hgb_seg_tracker #(.SEG_COUNT(SEG_COUNT)) u_segs (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg_valid(seg_valid),
    .seg_value(seg_value),
    .frame_end(frame_end),
    .act_thr  (act_thr),
    .frame_hit(frame_hit)
  );

  hgb_frame_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_end(frame_end),
    .frame_hit(frame_hit),
    .act_dly  (act_dly),
    .status_q (status_q),
    .frame_cnt(frame_cnt),
    .eff_dly  (eff_dly),
    .event_set(event_set),
    .delay_err(delay_err)
  );

  // interrupt is refreshed once per frame
  always_ff @(posedge clk) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (frame_end) irq_q <= en_q && (status_q || event_set);
  end

  assign irq = irq_q;
endmodule

// File: rtl/hgb_irq_ctrl_chk.sv
module hgb_irq_ctrl_chk
  import hgb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             vblank_start,
  input logic             frame_end,
  input logic             irq,
  input logic             delay_err,
  input logic             en_q,
  input logic             status_q,
  input logic             frame_hit,
  input dly_t             frame_cnt,
  input dly_t             eff_dly,
  input dly_t             act_dly,
  input thr_t             act_thr
);
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(irq)); // R10
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !reg_wr) |=> (irq == (reg_rdata[EN_BIT] && reg_rdata[ST_BIT]))); // R10
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !en_q) |=> !irq); // R11
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !(reg_wr && reg_wdata[ST_BIT])) |=> status_q); // R8
  AST_STATUS_SET_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !frame_end) |=> !status_q); // R6
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> ($stable(act_dly) && $stable(act_thr))); // R3
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_hit) |=> (frame_cnt == '0)); // R5
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !vblank_start) |=> (frame_cnt <= eff_dly)); // R5
  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    delay_err |-> (eff_dly == dly_t'(1))); // R9
endmodule

bind hgb_irq_ctrl hgb_irq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .vblank_start(vblank_start),
  .frame_end   (frame_end),
  .irq         (irq),
  .delay_err   (delay_err),
  .en_q        (en_q),
  .status_q    (status_q),
  .frame_hit   (frame_hit),
  .frame_cnt   (frame_cnt),
  .eff_dly     (eff_dly),
  .act_dly     (act_dly),
  .act_thr     (act_thr)
);

// File: tb/hgb_irq_ctrl_test.sv
module hgb_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vblank_start = 1'b0;
  logic        frame_end = 1'b0;
  logic        seg_valid = 1'b0;
  logic [21:0] seg_value = '0;
  logic        irq;
  logic        delay_err;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hgb_irq_ctrl #(.SEG_COUNT(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vblank_start(vblank_start), .frame_end(frame_end),
    .seg_valid(seg_valid), .seg_value(seg_value), .irq(irq), .delay_err(delay_err)
  );

  function automatic logic [31:0] word(input logic en, input logic st,
                                       input logic [7:0] d, input logic [21:0] t);
    return {en, st, d, t};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic vblank();
    @(negedge clk); vblank_start = 1'b1;
    @(negedge clk); vblank_start = 1'b0;
  endtask

  task automatic seg(input logic [21:0] v);
    @(negedge clk); seg_valid = 1'b1; seg_value = v;
    @(negedge clk); seg_valid = 1'b0; seg_value = '0;
  endtask

  task automatic frame(input logic [21:0] s0, input logic [21:0] s1,
                       input logic [21:0] s2, input logic [21:0] s3,
                       input logic extra, input logic [21:0] ev);
    seg(s0); seg(s1); seg(s2); seg(s3);
    if (extra) seg(ev);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic chk_st(input string tag, input logic e);
    chk(tag, {31'd0, reg_rdata[30]}, {31'd0, e});
  endtask

  task automatic chk_irq(input string tag, input logic e);
    chk(tag, {31'd0, irq}, {31'd0, e});
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 32'h0);
    chk_irq("R1 irq", 1'b0);
    chk("R1 delay_err", {31'd0, delay_err}, 32'd1);
  endtask

  task automatic t_shadow();
    wr(word(1, 0, 8'd3, 22'd100));
    chk("R2 readback", reg_rdata, word(1, 0, 8'd3, 22'd100));
    chk("R3 active not yet loaded", {31'd0, delay_err}, 32'd1);
    vblank();
    chk("R3 loaded on vblank", {31'd0, delay_err}, 32'd0);
  endtask

  task automatic t_consecutive();
    frame(200, 0, 0, 0, 0, 0); chk_st("R5 one frame", 0);
    frame(0, 0, 0, 0, 0, 0);   chk_st("R5 two frames", 0);
    frame(0, 0, 0, 0, 0, 0);   chk_st("R5 miss resets", 0);
    frame(150, 0, 0, 0, 0, 0);
    frame(0, 0, 0, 0, 0, 0);   chk_st("R5 count restarted", 0);
    chk_irq("R10 before event", 0);
    frame(150, 0, 0, 0, 0, 0); chk_st("R6 third frame sets", 1);
    chk_irq("R10 irq with event", 1);
    frame(250, 0, 0, 0, 0, 0); chk_st("R8 held over miss", 1);
  endtask

  task automatic t_clear();
    wr(word(1, 0, 8'd3, 22'd100));
    chk("R7 write 0 keeps", reg_rdata, word(1, 1, 8'd3, 22'd100));
    wr(word(1, 1, 8'd3, 22'd100));
    chk_st("R7 write 1 clears", 0);
    chk_irq("R10 irq held until frame end", 1);
    frame(350, 0, 0, 0, 0, 0);
    chk_st("R4 equal difference is no hit", 0);
    chk_irq("R10 irq drops at frame end", 0);
  endtask

  task automatic t_saturate();
    frame(0, 0, 0, 0, 0, 0);
    frame(250, 0, 0, 0, 0, 0);
    frame(0, 0, 0, 0, 0, 0);   chk_st("R6 set again", 1);
    wr(word(1, 1, 8'd3, 22'd100));
    frame(250, 0, 0, 0, 0, 0); chk_st("R5 saturated count refires", 1);
    frame(0, 0, 0, 0, 0, 0);   chk_st("R8 still set", 1);
  endtask

  task automatic t_thr_shadow();
    wr(word(1, 1, 8'd3, 22'd1000));
    frame(200, 0, 0, 0, 0, 0); chk_st("R3 old threshold in force", 1);
    vblank();
    wr(word(1, 1, 8'd3, 22'd1000));
    frame(0, 0, 0, 0, 0, 0);   chk_st("R4 new threshold, within", 0);
    frame(1200, 0, 0, 0, 0, 0); chk_st("R5 one of three", 0);
  endtask

  task automatic t_zero_delay();
    wr(word(1, 1, 8'd0, 22'd100));
    chk("R3 error waits for vblank", {31'd0, delay_err}, 32'd0);
    vblank();
    chk("R9 error flag", {31'd0, delay_err}, 32'd1);
    frame(1200, 0, 0, 0, 0, 0); chk_st("R9 miss", 0);
    frame(0, 0, 0, 0, 0, 0);    chk_st("R9 single frame fires", 1);
    chk_irq("R9 irq", 1);
  endtask

  task automatic t_disable();
    wr(word(0, 1, 8'd0, 22'd100));
    chk_irq("R10 hold after disable", 1);
    frame(500, 0, 0, 0, 0, 0);
    chk_st("R11 status still records", 1);
    chk_irq("R11 irq low when disabled", 0);
  endtask

  task automatic t_segments();
    wr(word(1, 1, 8'd0, 22'd100));
    frame(500, 0, 0, 0, 1, 22'd2000);
    chk_st("R4 extra segment ignored", 0);
    chk_irq("R4 irq low", 0);
    frame(500, 0, 300, 0, 0, 0);
    chk_st("R4 other segment hits", 1);
    chk_irq("R10 irq from segment 2", 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_consecutive();
    t_clear();
    t_saturate();
    t_thr_shadow();
    t_zero_delay();
    t_disable();
    t_segments();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule